// File: doc/BRIEF.md
# Multiplexer Function Generator

This block realises any Boolean function of four variables A, B, C and D with one eight-way multiplexer. Variables B, C and D drive the multiplexer's select lines. Each of its eight data inputs takes one of four residues: constant 0, constant 1, A, or the inverse of A. A is the most significant variable of the minterm index.

The residues are not written directly. The user presents a 16-bit minterm mask, where bit k is 1 when minterm k = {A,B,C,D} belongs to the function, and pulses a load strobe. On that clock edge the block turns each pair of minterms (k and k+8) into a 2-bit residue code and stores all eight codes. The outputs are combinational from the stored codes and the four variables.

An active-low enable forces the true output low and the complemented output high. While enable is low, the true output is the function value and the complemented output is its inverse.

Top module: `mux_func_gen`

## Requirements
- R1: After a synchronous reset, all residue codes are 0, so y is 0 for every one of the 16 variable combinations while enabled.
- R2: While en_n is 1, y is 0 and y_n is 1, whatever the variables and the stored codes.
- R3: While en_n is 0, y_n is always the inverse of y.
- R4: The select index is {B,C,D}, with B the most significant bit. The mask index is {A,B,C,D}, with A the most significant bit. A mask with a single minterm k therefore gives y = 1 for exactly that combination.
- R5: Data input n is built from mask bits n (A=0) and n+8 (A=1). If neither bit is set, the input is 0, and y stays 0 for both values of A.
- R6: If both bits of the pair are set, the input is 1, and y is 1 for both values of A.
- R7: If only bit n+8 is set, the input is A. If only bit n is set, the input is the inverse of A. The stored code is 00 for zero, 01 for one, 10 for A and 11 for the inverse of A.
- R8: For mask 16'h831B (minterms 0,1,3,4,8,9,15), the inputs become 1,1,0,A',A',0,0,A, and y matches the mask over all 16 combinations.
- R9: The codes change only on a rising edge with load high. A mask change with load low has no effect on y.
- R10: After any load, with en_n at 0, y equals mask bit {A,B,C,D} for every combination.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high; clears the codes |
| load | input | 1 | Captures the residue codes derived from mask |
| mask | input | 16 | Minterm mask; bit k is minterm {A,B,C,D} = k |
| en_n | input | 1 | Active-low output enable |
| var_a | input | 1 | Variable A, most significant |
| var_b | input | 1 | Variable B, select MSB |
| var_c | input | 1 | Variable C |
| var_d | input | 1 | Variable D, select LSB |
| y | output | 1 | Function output |
| y_n | output | 1 | Complemented output |

## Verification
The bench applies several kinds of mask:
- Single-minterm masks expose any swap of select-line order or of the A position.
- Uniform masks separate the four residue kinds: all clear, all set, only the upper half, only the lower half.
- The fixed seven-minterm example mixes every residue kind within one function.
- Many random masks, each swept over all 16 combinations, catch a wrong code mapping for any data input.

Between loads, the bench changes the mask with load low and with the outputs disabled, to show that only the strobe and the enable matter.

// File: rtl/mux_func_gen.sv
module mux_func_gen #(
  parameter int NSEL = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic [2*(1<<NSEL)-1:0]  mask,
  input  logic                    en_n,
  input  logic                    var_a,
  input  logic                    var_b,
  input  logic                    var_c,
  input  logic                    var_d,
  output logic                    y,
  output logic                    y_n
);
  localparam int NIN = 1 << NSEL;
  localparam int CW  = 2 * NIN;

  logic [CW-1:0]  codes_d, codes_q;
  logic [NIN-1:0] data_in;
  logic [NSEL-1:0] sel;
  logic            pick;

  for (genvar n = 0; n < NIN; n++) begin : g_res
    logic lo, hi;
    assign lo = mask[n];
    assign hi = mask[n+NIN];
    always_comb begin
      unique case ({hi, lo})
        2'b00: codes_d[2*n +: 2] = 2'b00;
        2'b11: codes_d[2*n +: 2] = 2'b01;
        2'b10: codes_d[2*n +: 2] = 2'b10;
        default: codes_d[2*n +: 2] = 2'b11;
      endcase
    end
    always_comb begin
      unique case (codes_q[2*n +: 2])
        2'b00: data_in[n] = 1'b0;
        2'b01: data_in[n] = 1'b1;
        2'b10: data_in[n] = var_a;
        default: data_in[n] = ~var_a;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       codes_q <= '0;
    else if (load) codes_q <= codes_d;
  end

  assign sel  = {var_b, var_c, var_d};
  assign pick = data_in[sel];
  assign y    = ~en_n & pick;
  assign y_n  = en_n | ~pick;
endmodule

// File: rtl/mux_func_gen_chk.sv
module mux_func_gen_chk (
  input logic        clk,
  input logic        rst,
  input logic        load,
  input logic [15:0] mask,
  input logic        en_n,
  input logic        var_a,
  input logic        var_b,
  input logic        var_c,
  input logic        var_d,
  input logic        y,
  input logic        y_n,
  input logic [15:0] codes_q
);
  logic [15:0] shadow;

  always_ff @(posedge clk) begin
    if (rst)       shadow <= '0;
    else if (load) shadow <= mask;
  end

  a_r2_disabled_outputs: assert property (@(posedge clk) disable iff (rst)
    en_n |-> (!y && y_n));

  a_r10_function_matches_mask: assert property (@(posedge clk) disable iff (rst)
    !en_n |-> (y == shadow[{var_a, var_b, var_c, var_d}]));

  a_r9_codes_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(codes_q));

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (codes_q == 16'h0));
endmodule

bind mux_func_gen mux_func_gen_chk chk_i (
  .clk(clk), .rst(rst), .load(load), .mask(mask), .en_n(en_n),
  .var_a(var_a), .var_b(var_b), .var_c(var_c), .var_d(var_d),
  .y(y), .y_n(y_n), .codes_q(codes_q)
);

// File: tb/mux_func_gen_tb_top.sv
module mux_func_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst, load, en_n, va, vb, vc, vd;
  logic [15:0] mask;
  logic        y, y_n;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  mux_func_gen dut_i (
    .clk(clk), .rst(rst), .load(load), .mask(mask), .en_n(en_n),
    .var_a(va), .var_b(vb), .var_c(vc), .var_d(vd), .y(y), .y_n(y_n)
  );

  task automatic check(input string req, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b (mask %h abcd %b%b%b%b en_n %b)",
               req, got, exp, mask, va, vb, vc, vd, en_n);
    end
  endtask

  task automatic apply(input logic [3:0] abcd);
    {va, vb, vc, vd} = abcd;
    #1;
  endtask

  task automatic do_load(input logic [15:0] m);
    @(negedge clk);
    mask = m; load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic sweep(input string req, input logic [15:0] m);
    for (int k = 0; k < 16; k++) begin
      apply(4'(k));
      check(req, y, m[k]);
      check("R3", y_n, ~m[k]);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1; load = 1'b0; en_n = 1'b0; mask = 16'hFFFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    sweep("R1", 16'h0000);
  endtask

  task automatic t_disable;
    do_load(16'hFFFF);
    en_n = 1'b1;
    for (int k = 0; k < 16; k++) begin
      apply(4'(k));
      check("R2", y, 1'b0);
      check("R2", y_n, 1'b1);
    end
    en_n = 1'b0;
    sweep("R6", 16'hFFFF);
  endtask

  task automatic t_residues;
    do_load(16'h0000); sweep("R5", 16'h0000);
    do_load(16'hFF00); sweep("R7", 16'hFF00);
    do_load(16'h00FF); sweep("R7", 16'h00FF);
    do_load(16'h5A3C); sweep("R7", 16'h5A3C);
  endtask

  task automatic t_select_order;
    for (int k = 0; k < 16; k++) begin
      do_load(16'(1) << k);
      sweep("R4", 16'(1) << k);
    end
  endtask

  task automatic t_example;
    do_load(16'h831B);
    sweep("R8", 16'h831B);
  endtask

  task automatic t_no_load;
    do_load(16'hA5C3);
    @(negedge clk); mask = 16'h5A3C;
    repeat (3) @(negedge clk);
    en_n = 1'b1; mask = 16'hFFFF;
    @(negedge clk);
    en_n = 1'b0;
    sweep("R9", 16'hA5C3);
  endtask

  task automatic t_random;
    for (int i = 0; i < 200; i++) begin
      logic [15:0] m;
      m = 16'($urandom);
      do_load(m);
      sweep("R10", m);
    end
  endtask

  initial begin
    va = 0; vb = 0; vc = 0; vd = 0;
    t_reset();
    t_disable();
    t_residues();
    t_select_order();
    t_example();
    t_no_load();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule